// File: doc/BRIEF.md
# Write Eye Centering Training Sequencer

This block trains the write data delay of every byte lane of a DDR interface so that the write strobe sits in the middle of the write data eye. A start pulse opens a training run. The block writes a known pattern through a simple memory request port and reads it back. It compares the returned byte of each lane against the expected pattern. It then steps each lane's write data delay code down and then up, one tap per write/read round, to find both edges of that lane's passing window. Every lane then gets the midpoint, and one more write/read round confirms the result.

All lanes train in the same rounds, but each lane keeps its own edges, its own delay code and its own result. A lane that fails the first compare is dropped from the rest of the run and keeps its starting delay. The block reports a done flag, a global error flag, and a per-lane error bit, warning bit and 4-bit status code. The status code tells a failure before centering apart from a failure after it.

Top module: `wec_top`

## Requirements
- R1: A start pulse while idle clears every lane's error, warning and status, and the done flag, on the next clock edge. Done stays low while training runs.
- R2: The first memory request of a run is a write, and the next is a read. The write data byte of lane k is 8'hA5 XOR k. A lane passes a compare only when its returned byte equals that value.
- R3: A lane whose first compare fails sets its error bit with status 4'b0000. Its delay stays at its starting code, and it takes no part in the sweeps or the confirmation.
- R4: For each passing lane the delay moves down one tap per compare from the starting code. The search stops at the first failing code or after code 0 passes. The left edge is the lowest code that passed.
- R5: The delay then moves up one tap per compare from one above the starting code. The search stops at the first failing code or after code 511 passes. The right edge is the highest code that passed.
- R6: Each passing lane is programmed to (left + right) >> 1 on its 9-bit write delay output.
- R7: A lane whose window width (right - left + 1) is below min_width sets its warning bit, and it is still programmed to the center.
- R8: A lane that fails the confirmation compare at its center sets its error bit with status 4'b0101.
- R9: Done rises at the end of every run, including runs with errors, and holds until the next start. err_any is the OR of the lane error bits.
- R10: Lanes are independent. One lane's window, failure or early stop does not change another lane's edges, delay or status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that starts a training run |
| init_dly | input | NL*DW | Starting write data delay code of each lane |
| min_width | input | DW+1 | Narrowest window width that gives no warning |
| mem_req | output | 1 | Memory request strobe, one cycle per request |
| mem_we | output | 1 | Request is a write (1) or a read (0) |
| mem_wdata | output | NL*BW | Pattern bytes for a write, lane k in bits k*BW upward |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | NL*BW | Returned bytes, same lane order |
| wr_dly | output | NL*DW | Current write data delay code of each lane |
| done | output | 1 | Training finished |
| err_any | output | 1 | OR of lane error bits |
| lane_err | output | NL | Per-lane error bit |
| lane_warn | output | NL | Per-lane narrow-window warning |
| lane_stat | output | NL*4 | Per-lane status code |

## Verification
The vectors place windows against code 0 and code 511, so a design that wrapped the delay past either end would report a wrong edge and a wrong center. Windows one tap wide and windows exactly min_width wide check the warning rule at its boundary, where an off-by-one in the width would flip the warning bit. Some lanes fail their first compare, and those lanes must keep their starting code while their neighbours still center correctly. A lane that shared search state would pull the other lanes off. The memory model also fails a lane on its second visit to its center code, which only the confirmation round makes. This checks the 4'b0101 code and shows that done still rises with err_any set.

// File: rtl/wec_pkg.sv
package wec_pkg;

    typedef enum logic [2:0] {
        C_NONE,
        C_CLEAR,
        C_INIT_RES,
        C_LEFT_RES,
        C_RIGHT_START,
        C_RIGHT_RES,
        C_CENTER,
        C_CONF_RES
    } wec_cmd_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WR,
        S_RD,
        S_WAIT,
        S_NEXT
    } wec_state_e;

    typedef enum logic [1:0] {
        PH_INIT,
        PH_LEFT,
        PH_RIGHT,
        PH_CONF
    } wec_phase_e;

    localparam logic [3:0] STAT_PRE  = 4'b0000;
    localparam logic [3:0] STAT_POST = 4'b0101;

    function automatic logic [63:0] pat_word(input int lane);
        return {56'h0, 8'hA5} ^ 64'(lane);
    endfunction

endpackage

// File: rtl/wec_cmp.sv
module wec_cmp #(
    parameter int NL = 4,
    parameter int BW = 8
) (
    input  logic [NL*BW-1:0] rdata,
    output logic [NL*BW-1:0] wdata,
    output logic [NL-1:0]    pass
);
    import wec_pkg::*;

    for (genvar k = 0; k < NL; k++) begin : g_lane
        localparam logic [63:0] PW = pat_word(k);
        assign wdata[k*BW +: BW] = PW[BW-1:0];
        assign pass[k] = (rdata[k*BW +: BW] == PW[BW-1:0]);
    end

endmodule

// File: rtl/wec_lane.sv
module wec_lane #(
    parameter int DW = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  wec_pkg::wec_cmd_e cmd,
    input  logic              pass,
    input  logic [DW-1:0]     init_dly,
    input  logic [DW:0]       min_width,
    output logic [DW-1:0]     dly,
    output logic              srch,
    output logic              err,
    output logic              warn,
    output logic [3:0]        estat
);
    import wec_pkg::*;

    localparam logic [DW-1:0] MAXD = {DW{1'b1}};

    logic [DW-1:0] left_q, right_q;
    logic          alive;
    logic [DW:0]   sum, width;

    assign sum   = {1'b0, left_q} + {1'b0, right_q};
    assign width = {1'b0, right_q} - {1'b0, left_q} + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            dly     <= '0;
            left_q  <= '0;
            right_q <= '0;
            alive   <= 1'b0;
            srch    <= 1'b0;
            err     <= 1'b0;
            warn    <= 1'b0;
            estat   <= STAT_PRE;
        end else begin
            unique case (cmd)
                C_CLEAR: begin
                    dly     <= init_dly;
                    left_q  <= init_dly;
                    right_q <= init_dly;
                    alive   <= 1'b1;
                    srch    <= 1'b0;
                    err     <= 1'b0;
                    warn    <= 1'b0;
                    estat   <= STAT_PRE;
                end
                C_INIT_RES: begin
                    if (pass) begin
                        left_q  <= dly;
                        right_q <= dly;
                        if (dly == '0) srch <= 1'b0;
                        else begin
                            dly  <= dly - 1'b1;
                            srch <= 1'b1;
                        end
                    end else begin
                        err   <= 1'b1;
                        estat <= STAT_PRE;
                        alive <= 1'b0;
                    end
                end
                C_LEFT_RES: begin
                    if (srch) begin
                        if (pass) begin
                            left_q <= dly;
                            if (dly == '0) srch <= 1'b0;
                            else dly <= dly - 1'b1;
                        end else begin
                            srch <= 1'b0;
                        end
                    end
                end
                C_RIGHT_START: begin
                    if (alive) begin
                        if (right_q == MAXD) srch <= 1'b0;
                        else begin
                            dly  <= right_q + 1'b1;
                            srch <= 1'b1;
                        end
                    end
                end
                C_RIGHT_RES: begin
                    if (srch) begin
                        if (pass) begin
                            right_q <= dly;
                            if (dly == MAXD) srch <= 1'b0;
                            else dly <= dly + 1'b1;
                        end else begin
                            srch <= 1'b0;
                        end
                    end
                end
                C_CENTER: begin
                    if (alive) begin
                        dly  <= sum[DW:1];
                        warn <= (width < min_width);
                    end
                end
                C_CONF_RES: begin
                    if (alive && !pass) begin
                        err   <= 1'b1;
                        estat <= STAT_POST;
                    end
                end
                default: ;
            endcase
        end
    end

    p_stat_legal_r8: assert property (@(posedge clk) disable iff (rst)
        err |-> (estat == STAT_PRE || estat == STAT_POST));

    p_err_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        (err && cmd != C_CLEAR) |=> err);

    p_step_one_r4: assert property (@(posedge clk) disable iff (rst)
        ((cmd == C_LEFT_RES || cmd == C_RIGHT_RES) && srch) |=>
        (dly == $past(dly) + 1'b1 || dly == $past(dly) - 1'b1 || dly == $past(dly)));

    p_center_inside_r6: assert property (@(posedge clk) disable iff (rst)
        (cmd == C_CENTER && alive) |=> (dly >= left_q && dly <= right_q));

endmodule

// File: rtl/wec_seq.sv
module wec_seq (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              mem_rvalid,
    input  logic              any_srch,
    output wec_pkg::wec_cmd_e cmd,
    output logic              mem_req,
    output logic              mem_we,
    output logic              done
);
    import wec_pkg::*;

    wec_state_e state, state_n;
    wec_phase_e phase, phase_n;
    logic       done_n;

    always_comb begin
        state_n = state;
        phase_n = phase;
        done_n  = done;
        cmd     = C_NONE;
        mem_req = 1'b0;
        mem_we  = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (start) begin
                    cmd     = C_CLEAR;
                    done_n  = 1'b0;
                    phase_n = PH_INIT;
                    state_n = S_WR;
                end
            end
            S_WR: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                state_n = S_RD;
            end
            S_RD: begin
                mem_req = 1'b1;
                state_n = S_WAIT;
            end
            S_WAIT: begin
                if (mem_rvalid) begin
                    unique case (phase)
                        PH_INIT:  cmd = C_INIT_RES;
                        PH_LEFT:  cmd = C_LEFT_RES;
                        PH_RIGHT: cmd = C_RIGHT_RES;
                        default:  cmd = C_CONF_RES;
                    endcase
                    if (phase == PH_CONF) begin
                        done_n  = 1'b1;
                        state_n = S_IDLE;
                    end else begin
                        state_n = S_NEXT;
                    end
                end
            end
            S_NEXT: begin
                if (phase == PH_RIGHT) begin
                    if (any_srch) state_n = S_WR;
                    else begin
                        cmd     = C_CENTER;
                        phase_n = PH_CONF;
                        state_n = S_WR;
                    end
                end else begin
                    if (any_srch) begin
                        phase_n = PH_LEFT;
                        state_n = S_WR;
                    end else begin
                        cmd     = C_RIGHT_START;
                        phase_n = PH_RIGHT;
                    end
                end
            end
            default: state_n = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
            phase <= PH_INIT;
            done  <= 1'b0;
        end else begin
            state <= state_n;
            phase <= phase_n;
            done  <= done_n;
        end
    end

    p_wr_then_rd_r2: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |=> (mem_req && !mem_we));

    p_done_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done);

    p_quiet_when_done_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> !mem_req);

    p_start_clears_r1: assert property (@(posedge clk) disable iff (rst)
        (start && state == S_IDLE) |=> !done);

endmodule

// File: rtl/wec_top.sv
module wec_top #(
    parameter int NL = 4,
    parameter int DW = 9,
    parameter int BW = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [NL*DW-1:0] init_dly,
    input  logic [DW:0]      min_width,
    output logic             mem_req,
    output logic             mem_we,
    output logic [NL*BW-1:0] mem_wdata,
    input  logic             mem_rvalid,
    input  logic [NL*BW-1:0] mem_rdata,
    output logic [NL*DW-1:0] wr_dly,
    output logic             done,
    output logic             err_any,
    output logic [NL-1:0]    lane_err,
    output logic [NL-1:0]    lane_warn,
    output logic [NL*4-1:0]  lane_stat
);
    import wec_pkg::*;

    wec_cmd_e      cmd;
    logic [NL-1:0] pass, srch;

    wec_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .mem_rvalid (mem_rvalid),
        .any_srch   (|srch),
        .cmd        (cmd),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .done       (done)
    );

    wec_cmp #(.NL(NL), .BW(BW)) u_cmp (
        .rdata (mem_rdata),
        .wdata (mem_wdata),
        .pass  (pass)
    );

    for (genvar k = 0; k < NL; k++) begin : g_lane
        wec_lane #(.DW(DW)) u_lane (
            .clk       (clk),
            .rst       (rst),
            .cmd       (cmd),
            .pass      (pass[k]),
            .init_dly  (init_dly[k*DW +: DW]),
            .min_width (min_width),
            .dly       (wr_dly[k*DW +: DW]),
            .srch      (srch[k]),
            .err       (lane_err[k]),
            .warn      (lane_warn[k]),
            .estat     (lane_stat[k*4 +: 4])
        );
    end

    assign err_any = |lane_err;

endmodule

// File: tb/sim_wec_top.sv
`timescale 1ns/1ps
module sim_wec_top;
    localparam int NL = 4;
    localparam int DW = 9;
    localparam int BW = 8;
    localparam int NV = 4;
    localparam int NOTRAP = 1023;

    // scenario x lane x {init, lo, hi, trap}
    localparam int VEC [NV][NL][4] = '{
        '{'{100, 80, 140, NOTRAP}, '{200, 150, 260, NOTRAP},
          '{50, 0, 90, NOTRAP},    '{480, 430, 511, NOTRAP}},
        '{'{300, 10, 40, NOTRAP},  '{60, 40, 80, 60},
          '{20, 18, 22, NOTRAP},   '{100, 100, 107, NOTRAP}},
        '{'{5, 5, 5, NOTRAP},      '{511, 511, 511, NOTRAP},
          '{0, 1, 9, NOTRAP},      '{12, 10, 21, 15}},
        '{'{7, 100, 200, NOTRAP},  '{400, 0, 20, NOTRAP},
          '{0, 300, 511, NOTRAP},  '{511, 0, 510, NOTRAP}}
    };
    localparam int MINW [NV] = '{16, 8, 1, 4};

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic [NL*DW-1:0] init_dly = '0;
    logic [DW:0]      min_width = '0;
    logic             mem_req, mem_we, mem_rvalid;
    logic [NL*BW-1:0] mem_wdata, mem_rdata, wr_dly_unused;
    logic [NL*DW-1:0] wr_dly;
    logic             done, err_any;
    logic [NL-1:0]    lane_err, lane_warn;
    logic [NL*4-1:0]  lane_stat;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    wec_top #(.NL(NL), .DW(DW), .BW(BW)) u0 (
        .clk(clk), .rst(rst), .start(start), .init_dly(init_dly),
        .min_width(min_width), .mem_req(mem_req), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .wr_dly(wr_dly), .done(done), .err_any(err_any),
        .lane_err(lane_err), .lane_warn(lane_warn), .lane_stat(lane_stat)
    );
    assign wr_dly_unused = '0;

    // memory model: per-lane pass window, plus a trap code failing on its second visit
    int            m_lo [NL], m_hi [NL], m_trap [NL], visits [NL];
    logic [BW-1:0] stor [NL];
    logic          rp1 = 1'b0;
    int            req_seen = 0;
    logic          first_we [2];
    logic [NL*BW-1:0] first_wd;

    initial begin
        mem_rvalid = 1'b0;
        mem_rdata  = '0;
        for (int k = 0; k < NL; k++) stor[k] = '0;
    end

    always @(posedge clk) begin
        mem_rvalid <= rp1;
        rp1 <= mem_req && !mem_we && !rst;
        if (rp1)
            for (int k = 0; k < NL; k++) mem_rdata[k*BW +: BW] <= stor[k];
        if (mem_req && !rst) begin
            if (req_seen < 2) first_we[req_seen] = mem_we;
            if (req_seen == 0) first_wd = mem_wdata;
            req_seen++;
        end
        if (mem_req && mem_we && !rst)
            for (int k = 0; k < NL; k++) begin
                int  d;
                bit  ok;
                d  = int'(wr_dly[k*DW +: DW]);
                ok = (d >= m_lo[k]) && (d <= m_hi[k]);
                if (d == m_trap[k]) begin
                    if (visits[k] > 0) ok = 1'b0;
                    visits[k]++;
                end
                stor[k] <= ok ? mem_wdata[k*BW +: BW] : ~mem_wdata[k*BW +: BW];
            end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic run_vec(input int s);
        int  t;
        bit  any_e;
        for (int k = 0; k < NL; k++) begin
            init_dly[k*DW +: DW] = DW'(VEC[s][k][0]);
            m_lo[k]   = VEC[s][k][1];
            m_hi[k]   = VEC[s][k][2];
            m_trap[k] = VEC[s][k][3];
            visits[k] = 0;
        end
        min_width = (DW+1)'(MINW[s]);
        req_seen  = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(done == 1'b0, "R1", "done cleared by start", int'(done), 0);
        chk(lane_err == '0 && lane_warn == '0, "R1", "status cleared by start",
            int'({lane_err, lane_warn}), 0);
        t = 0;
        while (!done && t < 20000) begin
            @(negedge clk);
            t++;
        end
        if (!done) begin
            chk(1'b0, "R9", "watchdog: done never rose", 0, 1);
            finish_run();
        end
        chk(first_we[0] == 1'b1 && first_we[1] == 1'b0, "R2", "write then read order",
            int'({first_we[0], first_we[1]}), 2);
        any_e = 1'b0;
        for (int k = 0; k < NL; k++) begin
            int init, lo, hi, trap, exp_d, exp_s, act_d;
            bit exp_e, exp_w;
            init = VEC[s][k][0]; lo = VEC[s][k][1]; hi = VEC[s][k][2]; trap = VEC[s][k][3];
            chk(first_wd[k*BW +: BW] == (8'hA5 ^ 8'(k)), "R2", "pattern byte",
                int'(first_wd[k*BW +: BW]), int'(8'hA5 ^ 8'(k)));
            if (init < lo || init > hi) begin
                exp_e = 1'b1; exp_s = 0; exp_w = 1'b0; exp_d = init;
            end else begin
                exp_d = (lo + hi) / 2;
                exp_w = (hi - lo + 1) < MINW[s];
                exp_e = (trap == exp_d);
                exp_s = exp_e ? 5 : 0;
            end
            any_e |= exp_e;
            act_d = int'(wr_dly[k*DW +: DW]);
            chk(lane_err[k] == exp_e, exp_s == 5 ? "R8" : "R3", "lane error bit",
                int'(lane_err[k]), int'(exp_e));
            chk(int'(lane_stat[k*4 +: 4]) == exp_s, exp_s == 5 ? "R8" : "R3",
                "lane status code", int'(lane_stat[k*4 +: 4]), exp_s);
            chk(lane_warn[k] == exp_w, "R7", "lane warning bit",
                int'(lane_warn[k]), int'(exp_w));
            chk(act_d == exp_d, "R4 R5 R6 R10", "lane delay code", act_d, exp_d);
        end
        chk(err_any == any_e, "R9", "err_any", int'(err_any), int'(any_e));
        repeat (3) @(negedge clk);
        chk(done == 1'b1, "R9", "done holds", int'(done), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(done == 1'b0, "R1", "reset done", int'(done), 0);
        chk(err_any == 1'b0 && lane_err == '0, "R9", "reset errors", int'(lane_err), 0);
        chk(mem_req == 1'b0, "R2", "reset no request", int'(mem_req), 0);
        for (int s = 0; s < NV; s++) run_vec(s);
        // directed: a clean run after an all-fail run clears every lane (R1, R10)
        run_vec(0);
        chk(lane_stat == '0, "R1", "status clean after rerun", int'(lane_stat), 0);
        finish_run();
    end

    initial begin
        repeat (190000) @(posedge clk);
        chk(1'b0, "R9", "global watchdog", 0, 1);
        finish_run();
    end

endmodule